// File: doc/BRIEF.md
# Scalar Double-to-Single Converter Lane

This block takes the low 64-bit IEEE-754 double-precision element of a second source vector, rounds it to single precision and writes the result into the lowest 32-bit lane of a destination vector. The other lanes of the destination are set by one of three write-back forms. The keep form leaves every upper bit as it was. The copy form takes lanes 1 to 3 from a first source and clears everything above bit 127. The masked form does the same as the copy form, and also gates lane 0 with a one-bit write mask that selects between merging the old value and zeroing it.

Rounding follows a default mode input. In the masked form only, a static override can replace that mode for one operation. Five sticky exception flags collect the invalid, denormal-operand, overflow, underflow and inexact conditions of every operation that writes its lane. A one-cycle registered stage holds the new destination vector and a valid strobe.

Top module: `fp64_to_fp32_lane`

## Requirements
- R1: When `opValid` is high at a rising edge, bits 31:0 of `destOut` take the single-precision rounding of `src2Lo` at that edge, and `destValid` is high for exactly the following cycle. While `opValid` is low, `destOut` holds its value.
- R2: Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. `defaultRc` applies unless `formSel` is 2 and `rcOverride` is 1, in which case `rcCode` applies. In forms 0 and 1, `rcOverride` has no effect.
- R3: With `formSel` 0 (keep form; code 3 behaves the same), `destOut` bits above 31 equal the `oldDest` bits sampled with the operation.
- R4: With `formSel` 1 (copy form) or 2 (masked form), `destOut[127:32]` equals `src1Hi`.
- R5: With `formSel` 1 or 2, every `destOut` bit above 127 is zero.
- R6: With `formSel` 2, lane 0 gets the converted value when `maskBit` is 1. When `maskBit` is 0, lane 0 is zero if `zeroEn` is 1 and otherwise keeps `oldDest[31:0]`.
- R7: A masked-form operation with `maskBit` 0 leaves `excFlags` unchanged, even for a signalling NaN input.
- R8: A signalling NaN (quiet bit 51 clear) gives a quiet NaN that keeps the sign and payload bits 50:29 with bit 22 set, and raises invalid (flag bit 0). A quiet NaN propagates the same way without raising any flag.
- R9: A result beyond the single-precision range raises overflow (bit 2) and inexact (bit 4). The result is infinity for nearest-even, and for a rounding direction that points away from zero on that sign. Otherwise it is the largest finite value of that sign.
- R10: Values below the normal single range are denormalised and rounded. Tininess is judged before rounding. Underflow (bit 3) is raised only when the value is tiny and inexact. A subnormal double input raises denormal-operand (bit 1).
- R11: Zeros and infinities convert exactly, keep their sign and raise no flag. Any other inexact result raises inexact (bit 4).
- R12: `excFlags` bits accumulate by OR over the operations that write lane 0 and clear only on reset. Reset makes `destOut` zero, `excFlags` zero and `destValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Starts an operation on this edge |
| formSel | input | 2 | Write-back form: 0 keep, 1 copy, 2 masked, 3 as keep |
| maskBit | input | 1 | Write mask for lane 0 (masked form) |
| zeroEn | input | 1 | Zero lane 0 instead of merging when masked off |
| rcOverride | input | 1 | Static rounding override enable (masked form) |
| rcCode | input | 2 | Override rounding code |
| defaultRc | input | 2 | Default rounding code |
| oldDest | input | VEC_W | Previous destination vector |
| src1Hi | input | 96 | Bits 127:32 of the first source |
| src2Lo | input | 64 | Double-precision operand |
| destOut | output | VEC_W | New destination vector |
| destValid | output | 1 | Result registered in the previous cycle |
| excFlags | output | 5 | Sticky flags {inexact, underflow, overflow, denormal, invalid} |

## Verification
Two functions can meet in one cycle: the exception detection of the rounding core and the mask gating of the control. The bench provokes this by sending a signalling NaN through the masked form with the mask clear, once in merge mode and once in zero mode. It judges the result by checking that lane 0 shows the old or zeroed value and that the flags do not move. A second overlap is rounding carrying a subnormal into the smallest normal value while underflow is still reported. This is driven with a value just below the normal range and judged against a hand-worked expected value and flag set.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  localparam int DP_W   = 64;
  localparam int SP_W   = 32;
  localparam int LANE_W = 32;
  localparam int MID_W  = 96;

  typedef enum logic [1:0] {
    FORM_KEEP = 2'd0,
    FORM_COPY = 2'd1,
    FORM_MASK = 2'd2
  } cvtForm_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_DOWN    = 2'd1,
    RM_UP      = 2'd2,
    RM_ZERO    = 2'd3
  } rndMode_e;

  typedef enum logic [1:0] {
    L0_RESULT = 2'd0,
    L0_ZERO   = 2'd1,
    L0_KEEP   = 2'd2
  } lane0Sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      upperFromSrc1;
    logic      zeroHigh;
    lane0Sel_e lane0Sel;
    rndMode_e  rndMode;
    logic      flagEn;
  } cvtCtrl_t;

  // Bit 0 invalid ... bit 4 inexact
  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denorm;
    logic invalid;
  } cvtFlags_t;

endpackage

// File: rtl/fcvt_ctrl.sv
module fcvt_ctrl
  import fcvt_pkg::*;
(
  input  logic       [1:0] formSel,
  input  logic             maskBit,
  input  logic             zeroEn,
  input  logic             rcOverride,
  input  logic       [1:0] rcCode,
  input  logic       [1:0] defaultRc,
  output cvtCtrl_t         ctrl
);

  logic isMask;
  logic isCopy;
  logic laneWrite;

  always_comb begin
    isMask    = (formSel == FORM_MASK);
    isCopy    = (formSel == FORM_COPY) || isMask;
    laneWrite = !isMask || maskBit;

    ctrl.upperFromSrc1 = isCopy;
    ctrl.zeroHigh      = isCopy;
    ctrl.flagEn        = laneWrite;

    if (laneWrite)   ctrl.lane0Sel = L0_RESULT;
    else if (zeroEn) ctrl.lane0Sel = L0_ZERO;
    else             ctrl.lane0Sel = L0_KEEP;

    if (isMask && rcOverride) ctrl.rndMode = rndMode_e'(rcCode);
    else                      ctrl.rndMode = rndMode_e'(defaultRc);
  end

endmodule

// File: rtl/fcvt_core.sv
module fcvt_core
  import fcvt_pkg::*;
(
  input  logic      [DP_W-1:0] dIn,
  input  rndMode_e             rnd,
  output logic      [SP_W-1:0] sOut,
  output cvtFlags_t            flags
);

  localparam int FRAC_DP = 52;
  localparam int MANT_W  = FRAC_DP + 1;
  localparam int SH_W    = 6;
  localparam int SH_MAX  = 60;

  logic                sgn;
  logic [10:0]         ex;
  logic [FRAC_DP-1:0]  fr;
  logic                isNan, isInf, isZero, isSub;
  logic signed [12:0]  biasedSp;
  logic                tiny, ovfPre, ovfPost, useInf;
  logic [MANT_W-1:0]   mant, shifted;
  logic [SH_W-1:0]     shAmt;
  logic                lostBits, rndBit, stkBit, incr, inexactRaw;
  logic [22:0]         keptFrac;
  logic [30:0]         magPre, magRnd;

  assign sgn = dIn[63];
  assign ex  = dIn[62:52];
  assign fr  = dIn[51:0];

  always_comb begin
    isNan  = (ex == 11'h7FF) && (fr != '0);
    isInf  = (ex == 11'h7FF) && (fr == '0);
    isZero = (ex == '0) && (fr == '0);
    isSub  = (ex == '0) && (fr != '0);
    mant   = {!isSub, fr};

    // single-precision biased exponent, subnormals use exponent 1
    biasedSp = $signed({2'b00, (isSub ? 11'd1 : ex)}) - 13'sd896;
    tiny     = biasedSp < 13'sd1;
    ovfPre   = !tiny && (biasedSp > 13'sd254);

    if (!tiny)                     shAmt = '0;
    else if (biasedSp < -13'sd58)  shAmt = SH_W'(SH_MAX);
    else                           shAmt = SH_W'(13'sd1 - biasedSp);

    shifted    = mant >> shAmt;
    lostBits   = |(mant & ((MANT_W'(1) << shAmt) - MANT_W'(1)));
    keptFrac   = shifted[51:29];
    rndBit     = shifted[28];
    stkBit     = (|shifted[27:0]) | lostBits;
    inexactRaw = rndBit | stkBit;

    unique case (rnd)
      RM_NEAREST: incr = rndBit & (stkBit | keptFrac[0]);
      RM_DOWN:    incr = inexactRaw & sgn;
      RM_UP:      incr = inexactRaw & !sgn;
      default:    incr = 1'b0;
    endcase

    // one adder: carry from fraction ripples into exponent
    magPre  = tiny ? {8'd0, keptFrac} : {biasedSp[7:0], keptFrac};
    magRnd  = magPre + {30'd0, incr};
    ovfPost = ovfPre || (magRnd[30:23] == 8'hFF);
    useInf  = (rnd == RM_NEAREST) || (rnd == RM_UP && !sgn) || (rnd == RM_DOWN && sgn);

    flags = '0;
    if (isNan) begin
      sOut          = {sgn, 8'hFF, 1'b1, fr[50:29]};
      flags.invalid = !fr[51];
    end else if (isInf) begin
      sOut = {sgn, 8'hFF, 23'd0};
    end else if (isZero) begin
      sOut = {sgn, 31'd0};
    end else if (ovfPost) begin
      sOut           = useInf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
      flags.overflow = 1'b1;
      flags.inexact  = 1'b1;
      flags.denorm   = isSub;
    end else begin
      sOut            = {sgn, magRnd};
      flags.inexact   = inexactRaw;
      flags.underflow = tiny & inexactRaw;
      flags.denorm    = isSub;
    end
  end

  always_comb begin
    if (!$isunknown(dIn)) begin
      // R8: any NaN input leaves as a quiet NaN
      if (isNan) a_r8_nan_quiet: assert (sOut[30:22] == 9'h1FF)
        else $error("a_r8_nan_quiet");
      // R11: zero and infinity are exact
      if (isZero || isInf) a_r11_exact_special: assert (flags == '0 && sOut[31] == sgn)
        else $error("a_r11_exact_special");
      // R10: the shifter leaves the hidden bit only for non-tiny values
      if (!isNan && !isInf && !isZero) a_r10_lead_bit: assert (shifted[52] == !tiny)
        else $error("a_r10_lead_bit");
    end
  end

endmodule

// File: rtl/fcvt_datapath.sv
module fcvt_datapath
  import fcvt_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  cvtCtrl_t         ctrl,
  input  logic [VEC_W-1:0] oldDest,
  input  logic [MID_W-1:0] src1Hi,
  input  logic [DP_W-1:0]  src2Lo,
  output logic [VEC_W-1:0] destOut,
  output logic             destValid,
  output logic [4:0]       excFlags
);

  localparam int LANES     = VEC_W / LANE_W;
  localparam int MID_LANES = 4;

  logic [SP_W-1:0]  convRes;
  cvtFlags_t        convFlags;
  logic [VEC_W-1:0] nextDest;
  logic [VEC_W-1:0] destQ;
  logic             validQ;
  cvtFlags_t        flagsQ;

  fcvt_core u_core (
    .dIn   (src2Lo),
    .rnd   (ctrl.rndMode),
    .sOut  (convRes),
    .flags (convFlags)
  );

  always_comb begin
    unique case (ctrl.lane0Sel)
      L0_RESULT: nextDest[LANE_W-1:0] = convRes;
      L0_ZERO:   nextDest[LANE_W-1:0] = '0;
      default:   nextDest[LANE_W-1:0] = oldDest[LANE_W-1:0];
    endcase
  end

  for (genvar g = 1; g < LANES; g++) begin : g_lane
    if (g < MID_LANES) begin : g_mid
      assign nextDest[g*LANE_W +: LANE_W] = ctrl.upperFromSrc1 ? src1Hi[(g-1)*LANE_W +: LANE_W]
                                                               : oldDest[g*LANE_W +: LANE_W];
    end else begin : g_high
      assign nextDest[g*LANE_W +: LANE_W] = ctrl.zeroHigh ? '0 : oldDest[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destQ  <= '0;
      validQ <= 1'b0;
      flagsQ <= '0;
    end else begin
      validQ <= opValid;
      if (opValid) begin
        destQ <= nextDest;
        if (ctrl.flagEn) flagsQ <= flagsQ | convFlags;
      end
    end
  end

  assign destOut   = destQ;
  assign destValid = validQ;
  assign excFlags  = flagsQ;

  // R12: flags never drop once set
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & $past(flagsQ)) == $past(flagsQ))
    else $error("a_r12_sticky");

  // R9: overflow always comes with inexact
  a_r9_ovf_inexact: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsQ.overflow) |-> flagsQ.inexact)
    else $error("a_r9_ovf_inexact");

  // R1: valid strobe follows the request by one cycle
  a_r1_valid: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> destValid)
    else $error("a_r1_valid");

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(destOut) && !destValid))
    else $error("a_r1_hold");

endmodule

// File: rtl/fp64_to_fp32_lane.sv
module fp64_to_fp32_lane
  import fcvt_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       formSel,
  input  logic             maskBit,
  input  logic             zeroEn,
  input  logic             rcOverride,
  input  logic [1:0]       rcCode,
  input  logic [1:0]       defaultRc,
  input  logic [VEC_W-1:0] oldDest,
  input  logic [95:0]      src1Hi,
  input  logic [63:0]      src2Lo,
  output logic [VEC_W-1:0] destOut,
  output logic             destValid,
  output logic [4:0]       excFlags
);

  cvtCtrl_t ctrl;

  fcvt_ctrl u_ctrl (
    .formSel    (formSel),
    .maskBit    (maskBit),
    .zeroEn     (zeroEn),
    .rcOverride (rcOverride),
    .rcCode     (rcCode),
    .defaultRc  (defaultRc),
    .ctrl       (ctrl)
  );

  fcvt_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .ctrl      (ctrl),
    .oldDest   (oldDest),
    .src1Hi    (src1Hi),
    .src2Lo    (src2Lo),
    .destOut   (destOut),
    .destValid (destValid),
    .excFlags  (excFlags)
  );

  logic keepForm, wideForm, blockedOp;
  assign keepForm  = (formSel != FORM_COPY) && (formSel != FORM_MASK);
  assign wideForm  = !keepForm;
  assign blockedOp = (formSel == FORM_MASK) && !maskBit;

  a_r3_keep_upper: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && keepForm) |=> destOut[VEC_W-1:32] == $past(oldDest[VEC_W-1:32]))
    else $error("a_r3_keep_upper");

  a_r4_copy_mid: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && wideForm) |=> destOut[127:32] == $past(src1Hi))
    else $error("a_r4_copy_mid");

  if (VEC_W > 128) begin : g_high_chk
    a_r5_zero_high: assert property (@(posedge clk) disable iff (!rstN)
      (opValid && wideForm) |=> destOut[VEC_W-1:128] == '0)
      else $error("a_r5_zero_high");
  end

  a_r6_merge_lane0: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && blockedOp && !zeroEn) |=> destOut[31:0] == $past(oldDest[31:0]))
    else $error("a_r6_merge_lane0");

  a_r7_blocked_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && blockedOp) |=> $stable(excFlags))
    else $error("a_r7_blocked_flags");

endmodule

// File: tb/test_fp64_to_fp32_lane.sv
module test_fp64_to_fp32_lane;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 512;
  localparam int NVEC = 28;

  typedef struct packed {
    logic [1:0]  form;
    logic        mask;
    logic        zero;
    logic        ovr;
    logic [1:0]  rc;
    logic [1:0]  defRc;
    logic [63:0] src;
    logic [31:0] expLo;
    logic [4:0]  expFl;
    logic [3:0]  req;
  } vec_t;

  // flags: 01 invalid, 02 denormal, 04 overflow, 08 underflow, 10 inexact
  localparam vec_t VECS [NVEC] = '{
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h3FF0000000000000,32'h3F800000,5'h00,4'd1},  // R1
    '{2'd1,1'b0,1'b0,1'b0,2'd0,2'd0,64'hC004000000000000,32'hC0200000,5'h00,4'd1},  // R1 R4
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h3FD5555555555555,32'h3EAAAAAB,5'h10,4'd2},  // R2 R11
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd3,64'h3FD5555555555555,32'h3EAAAAAA,5'h10,4'd2},  // R2
    '{2'd1,1'b0,1'b0,1'b0,2'd0,2'd2,64'h3FD5555555555555,32'h3EAAAAAB,5'h10,4'd2},  // R2
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd1,64'hBFD5555555555555,32'hBEAAAAAB,5'h10,4'd2},  // R2
    '{2'd2,1'b1,1'b0,1'b1,2'd3,2'd0,64'h3FD5555555555555,32'h3EAAAAAA,5'h10,4'd2},  // R2 override
    '{2'd1,1'b0,1'b0,1'b1,2'd3,2'd0,64'h3FD5555555555555,32'h3EAAAAAB,5'h10,4'd2},  // R2 ignored
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h47F0000000000000,32'h7F800000,5'h14,4'd9},  // R9
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd3,64'h47F0000000000000,32'h7F7FFFFF,5'h14,4'd9},  // R9
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd2,64'hC7F0000000000000,32'hFF7FFFFF,5'h14,4'd9},  // R9
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd1,64'hC7F0000000000000,32'hFF800000,5'h14,4'd9},  // R9
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h47EFFFFFF0000000,32'h7F800000,5'h14,4'd9},  // R9 carry
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h47EFFFFFE0000000,32'h7F7FFFFF,5'h00,4'd1},  // R1 max
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h7FF0000000000001,32'h7FC00000,5'h01,4'd8},  // R8
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h7FF4000000000000,32'h7FE00000,5'h01,4'd8},  // R8
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'hFFF8000000000000,32'hFFC00000,5'h00,4'd8},  // R8 quiet
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'hFFF0000000000000,32'hFF800000,5'h00,4'd11}, // R11
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h8000000000000000,32'h80000000,5'h00,4'd11}, // R11
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h3810000000000000,32'h00800000,5'h00,4'd10}, // R10
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h36A0000000000000,32'h00000001,5'h00,4'd10}, // R10 exact tiny
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h3690000000000000,32'h00000000,5'h18,4'd10}, // R10
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd2,64'h3690000000000000,32'h00000001,5'h18,4'd10}, // R10
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h3698000000000000,32'h00000001,5'h18,4'd10}, // R10
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h0000000000000001,32'h00000000,5'h1A,4'd10}, // R10 denormal
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd2,64'h0000000000000001,32'h00000001,5'h1A,4'd10}, // R10
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd1,64'h8000000000000001,32'h80000001,5'h1A,4'd10}, // R10
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,64'h380FFFFFF0000000,32'h00800000,5'h18,4'd10}  // R10 carry
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic [1:0]    formSel = '0;
  logic          maskBit = 1'b0;
  logic          zeroEn = 1'b0;
  logic          rcOverride = 1'b0;
  logic [1:0]    rcCode = '0;
  logic [1:0]    defaultRc = '0;
  logic [VW-1:0] oldDest = '0;
  logic [VW-1:0] src1Full = '0;
  logic [63:0]   src2Lo = '0;
  logic [VW-1:0] destOut;
  logic          destValid;
  logic [4:0]    excFlags;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp64_to_fp32_lane #(.VEC_W(VW)) i_fp64_to_fp32_lane (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .formSel    (formSel),
    .maskBit    (maskBit),
    .zeroEn     (zeroEn),
    .rcOverride (rcOverride),
    .rcCode     (rcCode),
    .defaultRc  (defaultRc),
    .oldDest    (oldDest),
    .src1Hi     (src1Full[127:32]),
    .src2Lo     (src2Lo),
    .destOut    (destOut),
    .destValid  (destValid),
    .excFlags   (excFlags)
  );

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected vector from the write-back requirements R3..R6
  function automatic logic [VW-1:0] expVec(input logic [1:0] form, input logic [31:0] lo);
    logic [VW-1:0] v;
    if (form == 2'd1 || form == 2'd2) begin
      v = '0;
      v[127:32] = src1Full[127:32];
    end else begin
      v = oldDest;
    end
    v[31:0] = lo;
    return v;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runOp(input logic [1:0] f, input logic m, input logic z, input logic o,
                       input logic [1:0] rc, input logic [1:0] dr, input logic [63:0] s);
    @(negedge clk);
    formSel = f; maskBit = m; zeroEn = z; rcOverride = o; rcCode = rc; defaultRc = dr;
    src2Lo = s; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < VW/32; i++) begin
      oldDest[i*32 +: 32]  = 32'hA5A50000 + i;
      src1Full[i*32 +: 32] = 32'h5A5A1000 + i;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R12 reset state
    chk("R12 reset dest", destOut, '0);
    chk("R12 reset flags", VW'(excFlags), '0);
    chk("R12 reset valid", VW'(destValid), '0);

    foreach (VECS[i]) begin
      doReset();
      runOp(VECS[i].form, VECS[i].mask, VECS[i].zero, VECS[i].ovr,
            VECS[i].rc, VECS[i].defRc, VECS[i].src);
      chk($sformatf("R%0d vec%0d dest", VECS[i].req, i), destOut, expVec(VECS[i].form, VECS[i].expLo));
      chk($sformatf("R%0d vec%0d flags", VECS[i].req, i), VW'(excFlags), VW'(VECS[i].expFl));
    end

    // R1 valid timing and hold
    doReset();
    runOp(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h3FF0000000000000);
    chk("R1 valid after op", VW'(destValid), VW'(1));
    @(negedge clk);
    chk("R1 valid drops", VW'(destValid), '0);
    chk("R1 dest holds", destOut, expVec(2'd0, 32'h3F800000));

    // R3 keep form, code 3 behaves as keep
    runOp(2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'hC004000000000000);
    chk("R3 code3 keeps upper", destOut, expVec(2'd0, 32'hC0200000));

    // R4 R5 copy form
    runOp(2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h3FF0000000000000);
    chk("R4 R5 copy form", destOut, expVec(2'd1, 32'h3F800000));

    // R6 R7 masked off, merge: sNaN must not flag
    doReset();
    runOp(2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h7FF0000000000001);
    chk("R6 masked merge lane0", destOut, expVec(2'd2, oldDest[31:0]));
    chk("R7 masked merge flags", VW'(excFlags), '0);

    // R6 R7 masked off, zeroing
    runOp(2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 64'h7FF0000000000001);
    chk("R6 masked zero lane0", destOut, expVec(2'd2, 32'h0));
    chk("R7 masked zero flags", VW'(excFlags), '0);

    // R6 mask set writes result even with zeroEn
    runOp(2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 64'h3FF0000000000000);
    chk("R6 mask set writes", destOut, expVec(2'd2, 32'h3F800000));

    // R12 sticky accumulation
    doReset();
    runOp(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h3FD5555555555555);
    runOp(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h3FF0000000000000);
    chk("R12 inexact stays", VW'(excFlags), VW'(5'h10));
    runOp(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h7FF0000000000001);
    chk("R12 invalid accumulates", VW'(excFlags), VW'(5'h11));
    runOp(2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h47F0000000000000);
    chk("R7 blocked overflow ignored", VW'(excFlags), VW'(5'h11));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule